// File: doc/BRIEF.md
# Codec Response Ring Writer

This block is the controller-side engine that stores codec responses into a circular ring in system memory. Each response arrives on a valid/ready stream with a 32-bit payload, the 4-bit address of the codec that sent it, and a flag that marks it as unsolicited. The block turns each response into one 8-byte entry and writes it through a memory write port. It then advances a hardware write pointer, so software can see how far the ring has been filled.

Software controls the block through plain pins. These set DMA enable, interrupt enable and the interrupt threshold N, clear the interrupt status bit (write-one-to-clear), and reset the write pointer. The status bit sets once N responses have been written since the response counter was last cleared. The interrupt line is that status bit gated by the interrupt enable.

Back-pressure rules: the response stream is accepted only when DMA is enabled and no entry is pending, so `rsp_ready` falls for at least one cycle after every transfer. A sender may hold `rsp_valid` high for as long as it likes. The memory port holds an entry until the memory accepts it, and the memory may stall that port for any number of cycles.

Top module: `resp_ring_writer`

## Requirements
- R1: `rsp_ready` is high only while DMA is enabled and no entry is waiting on the memory port. With DMA disabled, a held `rsp_valid` causes no memory write and leaves `wr_ptr` unchanged.
- R2: Each entry is 64 bits. Bits 31:0 hold the response, bits 35:32 hold the codec address, bit 36 is 1 for an unsolicited response, and bits 63:37 are zero.
- R3: An accepted response goes to slot `(wr_ptr + 1) mod 256`, at byte address `ring_base + 8 * slot`.
- R4: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` hold their values.
- R5: In the cycle after a memory handshake, `wr_ptr` equals the slot just written. The pointer therefore wraps from 255 to 0. Its value after reset is 0.
- R6: A pulse on `wp_rst` makes `wr_ptr` read 0 in the next cycle and clears the response counter.
- R7: `resp_int_sts` sets in the cycle after the Nth write completes since the counter was last cleared. N is taken from `thr_val` on `thr_wr`, with 0 meaning 256. The value of N after reset is 1.
- R8: With `sts_clr_wr` high and `sts_clr` high, the status bit clears. With `sts_clr` low, the write leaves the bit set. A new setting event in the same cycle wins over the clear.
- R9: `irq` is high exactly when `resp_int_sts` and `irq_en` are both high.
- R10: `dma_en_rd` reads 1 while a write is still in flight after DMA has been disabled. It drops in the cycle after that write completes.
- R11: The counter restarts each time the status sets, so the next setting needs N further writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | ADDR_W | Byte base address of the ring |
| ctl_wr | input | 1 | Load the control bits below |
| ctl_dma_en | input | 1 | DMA enable value |
| ctl_irq_en | input | 1 | Interrupt enable value |
| thr_wr | input | 1 | Load the interrupt threshold |
| thr_val | input | PTR_W | Threshold N (0 means 256) |
| sts_clr_wr | input | 1 | Status write strobe |
| sts_clr | input | 1 | Write-one-to-clear data for the status bit |
| wp_rst | input | 1 | Write-pointer reset pulse |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Response ready |
| rsp_data | input | 32 | Response payload |
| rsp_codec | input | 4 | Codec address of the response |
| rsp_unsol | input | 1 | Unsolicited response flag |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Byte address of the entry |
| mem_wr_data | output | 64 | Entry contents |
| wr_ptr | output | PTR_W | Hardware write pointer |
| dma_en_rd | output | 1 | DMA enable readback, held high while a write is in flight |
| irq_en | output | 1 | Interrupt enable readback |
| resp_int_sts | output | 1 | Response interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
A response is accepted on the rising edge where `rsp_valid` and `rsp_ready` are both high. `mem_wr_valid` rises one cycle later. The entry then completes on the first edge where `mem_wr_ready` is high. `wr_ptr`, `resp_int_sts`, `irq` and the drop of `dma_en_rd` all change on that completion edge. The bench counts completed handshakes in its memory model and samples all of these on the falling edge after the count moves. Control writes and `wp_rst` take effect one edge after their strobe, so they are sampled on the following falling edge.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  localparam int RESP_W  = 32;
  localparam int CODEC_W = 4;
  localparam int ENTRY_W = 64;

  typedef struct packed {
    logic [ENTRY_W-RESP_W-CODEC_W-2:0] zero;
    logic                              unsol;
    logic [CODEC_W-1:0]                codec;
    logic [RESP_W-1:0]                 resp;
  } entry_t;

  function automatic entry_t make_entry(input logic [RESP_W-1:0] r,
                                        input logic [CODEC_W-1:0] c,
                                        input logic u);
    entry_t e;
    e.zero  = '0;
    e.unsol = u;
    e.codec = c;
    e.resp  = r;
    return e;
  endfunction
endpackage

// File: rtl/rrw_ctrl.sv
module rrw_ctrl #(
  parameter int PTR_W = 8,
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_dma_en,
  input  logic             ctl_irq_en,
  input  logic             thr_wr,
  input  logic [PTR_W-1:0] thr_val,
  input  logic             sts_clr_wr,
  input  logic             sts_clr,
  input  logic             hit,
  input  logic             busy,
  output logic             dma_en,
  output logic             irq_en,
  output logic [CNT_W-1:0] thr,
  output logic             sts,
  output logic             dma_en_rd,
  output logic             irq
);
  localparam logic [CNT_W-1:0] FULL_RING = CNT_W'(1) << PTR_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en <= 1'b0;
      irq_en <= 1'b0;
      thr    <= CNT_W'(1);
      sts    <= 1'b0;
    end else begin
      if (ctl_wr) begin
        dma_en <= ctl_dma_en;
        irq_en <= ctl_irq_en;
      end
      if (thr_wr)
        thr <= (thr_val == '0) ? FULL_RING : CNT_W'(thr_val);
      if (hit)
        sts <= 1'b1;
      else if (sts_clr_wr && sts_clr)
        sts <= 1'b0;
    end
  end

  assign dma_en_rd = dma_en | busy;
  assign irq       = sts & irq_en;
endmodule

// File: rtl/rrw_ptr.sv
module rrw_ptr #(
  parameter int PTR_W = 8,
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_rst,
  input  logic             commit,
  input  logic [PTR_W-1:0] commit_slot,
  input  logic [CNT_W-1:0] thr,
  output logic [PTR_W-1:0] wp,
  output logic [PTR_W-1:0] next_slot,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic             reach;

  assign cnt_inc   = cnt + CNT_W'(1);
  assign reach     = (cnt_inc >= thr);
  assign next_slot = wp + PTR_W'(1);
  assign hit       = commit & ~wp_rst & reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
    end else if (wp_rst) begin
      wp  <= '0;
      cnt <= '0;
    end else if (commit) begin
      wp  <= commit_slot;
      cnt <= reach ? '0 : cnt_inc;
    end
  end
endmodule

// File: rtl/rrw_entry.sv
module rrw_entry
  import rrw_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_en,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [RESP_W-1:0]  s_data,
  input  logic [CODEC_W-1:0] s_codec,
  input  logic               s_unsol,
  input  logic [PTR_W-1:0]   next_slot,
  input  logic [ADDR_W-1:0]  base,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [ADDR_W-1:0]  m_addr,
  output logic [ENTRY_W-1:0] m_data,
  output logic               commit,
  output logic [PTR_W-1:0]   commit_slot,
  output logic               busy
);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);

  entry_t           held;
  logic [PTR_W-1:0] slot;

  assign s_ready = dma_en & ~busy;
  assign m_valid = busy;
  assign commit  = busy & m_ready;
  assign commit_slot = slot;
  assign m_data  = held;
  assign m_addr  = base + (ADDR_W'(slot) << ENTRY_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
      held <= '0;
    end else if (s_valid && s_ready) begin
      busy <= 1'b1;
      slot <= next_slot;
      held <= make_entry(s_data, s_codec, s_unsol);
    end else if (commit) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
  import rrw_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  ring_base,
  input  logic               ctl_wr,
  input  logic               ctl_dma_en,
  input  logic               ctl_irq_en,
  input  logic               thr_wr,
  input  logic [PTR_W-1:0]   thr_val,
  input  logic               sts_clr_wr,
  input  logic               sts_clr,
  input  logic               wp_rst,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [RESP_W-1:0]  rsp_data,
  input  logic [CODEC_W-1:0] rsp_codec,
  input  logic               rsp_unsol,
  output logic               mem_wr_valid,
  input  logic               mem_wr_ready,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [ENTRY_W-1:0] mem_wr_data,
  output logic [PTR_W-1:0]   wr_ptr,
  output logic               dma_en_rd,
  output logic               irq_en,
  output logic               resp_int_sts,
  output logic               irq
);
  localparam int CNT_W = PTR_W + 1;

  logic             dma_en;
  logic             busy;
  logic             commit;
  logic             hit;
  logic [CNT_W-1:0] thr;
  logic [PTR_W-1:0] next_slot;
  logic [PTR_W-1:0] commit_slot;

  rrw_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_dma_en(ctl_dma_en), .ctl_irq_en(ctl_irq_en),
    .thr_wr(thr_wr), .thr_val(thr_val),
    .sts_clr_wr(sts_clr_wr), .sts_clr(sts_clr),
    .hit(hit), .busy(busy),
    .dma_en(dma_en), .irq_en(irq_en), .thr(thr), .sts(resp_int_sts),
    .dma_en_rd(dma_en_rd), .irq(irq)
  );

  rrw_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wp_rst(wp_rst),
    .commit(commit), .commit_slot(commit_slot), .thr(thr),
    .wp(wr_ptr), .next_slot(next_slot), .hit(hit)
  );

  rrw_entry #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_entry (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
    .s_valid(rsp_valid), .s_ready(rsp_ready),
    .s_data(rsp_data), .s_codec(rsp_codec), .s_unsol(rsp_unsol),
    .next_slot(next_slot), .base(ring_base),
    .m_valid(mem_wr_valid), .m_ready(mem_wr_ready),
    .m_addr(mem_wr_addr), .m_data(mem_wr_data),
    .commit(commit), .commit_slot(commit_slot), .busy(busy)
  );
endmodule

// File: rtl/rrw_chk.sv
module rrw_chk #(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sts_clr_wr,
  input logic              sts_clr,
  input logic              wp_rst,
  input logic              rsp_ready,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [63:0]       mem_wr_data,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic              dma_en_rd,
  input logic              irq_en,
  input logic              resp_int_sts,
  input logic              irq
);
  assert_ready_needs_dma_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> dma_en_rd);

  assert_ready_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !rsp_ready);

  assert_ext_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> mem_wr_data[63:37] == '0);

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_wp_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wp_rst |=> wr_ptr == '0);

  assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_wr && sts_clr && !(mem_wr_valid && mem_wr_ready)) |=> !resp_int_sts);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_inflight_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> dma_en_rd);
endmodule

bind resp_ring_writer rrw_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_rrw_chk (
  .clk(clk), .rst_n(rst_n), .sts_clr_wr(sts_clr_wr), .sts_clr(sts_clr),
  .wp_rst(wp_rst), .rsp_ready(rsp_ready), .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data), .wr_ptr(wr_ptr), .dma_en_rd(dma_en_rd),
  .irq_en(irq_en), .resp_int_sts(resp_int_sts), .irq(irq)
);

// File: tb/test_resp_ring_writer.sv
`timescale 1ns/1ps
module test_resp_ring_writer;
  localparam int PTR_W  = 8;
  localparam int ADDR_W = 32;
  localparam int SLOTS  = 1 << PTR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] ring_base = 32'h0001_2000;
  logic              ctl_wr = 0, ctl_dma_en = 0, ctl_irq_en = 0;
  logic              thr_wr = 0;
  logic [PTR_W-1:0]  thr_val = '0;
  logic              sts_clr_wr = 0, sts_clr = 0, wp_rst = 0;
  logic              rsp_valid = 0;
  logic              rsp_ready;
  logic [31:0]       rsp_data = '0;
  logic [3:0]        rsp_codec = '0;
  logic              rsp_unsol = 0;
  logic              mem_wr_valid;
  logic              mem_wr_ready = 0;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [63:0]       mem_wr_data;
  logic [PTR_W-1:0]  wr_ptr;
  logic              dma_en_rd, irq_en, resp_int_sts, irq;

  resp_ring_writer #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) i_resp_ring_writer (.*);

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int rdy_mode = 1;  // 0 random, 1 always, 2 never
  int wcnt = 0;
  logic [63:0]       mem [SLOTS];
  logic [ADDR_W-1:0] last_addr;

  int exp_wp = 0;
  int exp_cnt = 0;
  int exp_thr = 1;
  bit exp_sts = 0;
  bit exp_ien = 0;

  function automatic logic [63:0] exp_entry(logic [31:0] d, logic [3:0] c, logic u);
    return {27'd0, u, c, d};
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(int slot);
    return ring_base + ADDR_W'(slot * 8);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rdy_mode == 1) mem_wr_ready = 1'b1;
    else if (rdy_mode == 2) mem_wr_ready = 1'b0;
    else mem_wr_ready = 1'($urandom % 2);
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (mem_wr_valid && mem_wr_ready) begin
      mem[(mem_wr_addr - ring_base) >> 3] <= mem_wr_data;
      last_addr <= mem_wr_addr;
      wcnt <= wcnt + 1;
    end
  end

  task automatic ctl(bit dma, bit ien);
    @(negedge clk);
    ctl_wr = 1; ctl_dma_en = dma; ctl_irq_en = ien; exp_ien = ien;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic set_thr(int n);
    @(negedge clk);
    thr_wr = 1; thr_val = PTR_W'(n); exp_thr = (n == 0) ? SLOTS : n;
    @(negedge clk);
    thr_wr = 0;
  endtask

  task automatic clr_sts(bit v);
    @(negedge clk);
    sts_clr_wr = 1; sts_clr = v;
    @(negedge clk);
    sts_clr_wr = 0; sts_clr = 0;
    if (v) exp_sts = 0;
  endtask

  task automatic pulse_wp_rst();
    @(negedge clk);
    wp_rst = 1;
    @(negedge clk);
    wp_rst = 0;
    exp_wp = 0; exp_cnt = 0;
  endtask

  task automatic accept(logic [31:0] d, logic [3:0] c, logic u);
    @(negedge clk);
    rsp_valid = 1; rsp_data = d; rsp_codec = c; rsp_unsol = u;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic finish_entry(logic [31:0] d, logic [3:0] c, logic u, int w0);
    int slot;
    while (wcnt == w0) @(negedge clk);
    slot = (exp_wp + 1) % SLOTS;
    exp_wp = slot;
    exp_cnt++;
    if (exp_cnt >= exp_thr) begin exp_cnt = 0; exp_sts = 1; end
    chk("R2 entry", mem[slot], exp_entry(d, c, u));
    chk("R3 addr", 64'(last_addr), 64'(exp_addr(slot)));
    chk("R5 wr_ptr", 64'(wr_ptr), 64'(slot));
    chk("R7 sts", 64'(resp_int_sts), 64'(exp_sts));
    chk("R9 irq", 64'(irq), 64'(exp_sts & exp_ien));
  endtask

  task automatic send(logic [31:0] d, logic [3:0] c, logic u);
    int w0;
    w0 = wcnt;
    accept(d, c, u);
    finish_entry(d, c, u, w0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset wr_ptr", 64'(wr_ptr), 0);
    chk("R7 reset sts", 64'(resp_int_sts), 0);
    chk("R1 reset ready", 64'(rsp_ready), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: DMA off, held valid does nothing
    rsp_valid = 1; rsp_data = 32'hDEAD_BEEF;
    repeat (10) begin
      @(negedge clk);
      chk("R1 ready low", 64'(rsp_ready), 0);
    end
    rsp_valid = 0;
    chk("R1 no write", 64'(wcnt), 0);
    chk("R1 wr_ptr kept", 64'(wr_ptr), 0);

    // N=1: every entry sets status
    ctl(1, 1);
    send(32'h1234_5678, 4'h3, 1'b0);
    send(32'hCAFE_0001, 4'hF, 1'b1);
    // R8 W1C
    clr_sts(0);
    chk("R8 write 0 keeps", 64'(resp_int_sts), 1);
    clr_sts(1);
    chk("R8 write 1 clears", 64'(resp_int_sts), 0);
    chk("R9 irq low", 64'(irq), 0);

    // R9 gating, R11 counter restart with N=3
    ctl(1, 0);
    set_thr(3);
    send(32'h0000_0011, 4'h1, 0);
    send(32'h0000_0022, 4'h2, 0);
    chk("R7 below N", 64'(resp_int_sts), 0);
    send(32'h0000_0033, 4'h3, 1);
    chk("R9 irq masked", 64'(irq), 0);
    clr_sts(1);
    send(32'h0000_0044, 4'h4, 0);
    send(32'h0000_0055, 4'h5, 0);
    chk("R11 restart", 64'(resp_int_sts), 0);

    // R6 pointer reset clears counter
    pulse_wp_rst();
    chk("R6 wr_ptr zero", 64'(wr_ptr), 0);
    send(32'h0000_0066, 4'h6, 0);
    chk("R6 counter cleared", 64'(resp_int_sts), 0);
    ctl(1, 1);
    send(32'h0000_0077, 4'h7, 0);
    send(32'h0000_0088, 4'h8, 0);
    chk("R6 third after reset", 64'(resp_int_sts), 1);
    clr_sts(1);

    // R4, R10: stalled memory, DMA disabled mid-flight
    rdy_mode = 2;
    begin
      int w0;
      logic [63:0] d0;
      logic [ADDR_W-1:0] a0;
      w0 = wcnt;
      accept(32'hABCD_0099, 4'h9, 1);
      d0 = mem_wr_data; a0 = mem_wr_addr;
      ctl(0, 1);
      repeat (3) @(negedge clk);
      chk("R4 valid held", 64'(mem_wr_valid), 1);
      chk("R4 data held", mem_wr_data, d0);
      chk("R4 addr held", 64'(mem_wr_addr), 64'(a0));
      chk("R10 readback high", 64'(dma_en_rd), 1);
      chk("R1 ready low pending", 64'(rsp_ready), 0);
      rdy_mode = 1;
      finish_entry(32'hABCD_0099, 4'h9, 1, w0);
      chk("R10 readback drops", 64'(dma_en_rd), 0);
    end

    // Random traffic with random memory stalls, pointer wraps (R5)
    ctl(1, 1);
    set_thr(5);
    clr_sts(1);
    rdy_mode = 0;
    void'($urandom(32'd7));
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      logic [3:0] c;
      logic u;
      d = $urandom; c = 4'($urandom); u = 1'($urandom);
      send(d, c, u);
      if (exp_sts && ($urandom % 4 == 0)) clr_sts(1);
    end

    // R7: N=0 means 256
    rdy_mode = 1;
    set_thr(0);
    pulse_wp_rst();
    clr_sts(1);
    for (int i = 0; i < 255; i++) send(32'(i), 4'(i), 0);
    chk("R7 255 of 256", 64'(resp_int_sts), 0);
    send(32'h0000_0100, 4'h0, 1);
    chk("R7 256th sets", 64'(resp_int_sts), 1);
    chk("R5 wrapped pointer", 64'(wr_ptr), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule